// File: doc/BRIEF.md
# Successive-Approximation Converter Start and Read Controller

This block is the digital control side of a successive-approximation converter. A host drives a chip-enable, an active-low chip-select, a read/convert select, an address bit and a static word-format strap. With the block enabled and selected, a convert command starts a bit-serial approximation and a read command presents the finished result on a modelled three-state data port.

The approximation runs one bit per clock, most significant bit first. Each cycle it presents a trial code, and an external comparator reports whether that code does not exceed the analog input. The address bit chooses the cycle length at convert time. It is held for the whole conversion and picks the byte at read time. The strap selects a single full-width word or two byte-wide reads on the upper eight data lines. Lane drive is shown by per-nibble enables and an overall output-enable flag.

Top module: `sarc_ctrl`

## Requirements
- R1: Unless `chip_en` is 1 and `chip_sel_n` is 0 in the same cycle, no conversion starts and `out_en`, `nib_en` and `dout` stay 0.
- R2: A convert command (`rd_cnvt`=0, enabled and selected) sampled at a clock edge while idle sets `busy` from that edge on.
- R3: With `addr_lo`=0 at the convert edge, `busy` stays high for exactly 12 cycles and the result equals the 12-bit code of the input.
- R4: With `addr_lo`=1 at the convert edge, `busy` stays high for exactly 8 cycles; the upper 8 result bits match the input and the lower 4 are 0.
- R5: While busy, `dac_code` is the bits resolved so far with the bit under test set: 0x800 in the first cycle, then {resolved MSB, 1, zeros}.
- R6: While `busy` is high, a read command leaves `out_en`, `nib_en` and `dout` at 0.
- R7: With `wide_fmt`=1, an idle read drives the full 12-bit result on `dout[11:0]` with `nib_en`=3'b111 in the same cycle.
- R8: With `wide_fmt`=0 and `addr_lo`=0, an idle read drives result bits 11..4 on `dout[11:4]`, `dout[3:0]`=0 and `nib_en`=3'b110.
- R9: With `wide_fmt`=0 and `addr_lo`=1, an idle read drives {result[3:0], 4'b0000} on `dout[11:4]`, `dout[3:0]`=0 and `nib_en`=3'b110.
- R10: A convert command during a conversion is ignored: the running cycle keeps its length and result.
- R11: After reset `busy`, `out_en`, `nib_en` and `dout` are 0.
- R12: The cycle length is set by `addr_lo` at the convert edge only; later changes of `addr_lo` do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_cnvt | input | 1 | 1 = read, 0 = convert |
| addr_lo | input | 1 | Cycle length at convert, byte select at read |
| wide_fmt | input | 1 | Strap: 1 = 12-bit word, 0 = two bytes |
| cmp_hi | input | 1 | Comparator: 1 when `dac_code` does not exceed the input |
| dac_code | output | 12 | Trial code for the comparator |
| busy | output | 1 | Conversion in progress |
| dout | output | 12 | Read data, meaningful while `out_en` is 1 |
| nib_en | output | 3 | Drive enable per nibble lane; bit 2 = bits 11..8 |
| out_en | output | 1 | Some lane is driven |

## Verification
Read paths are combinational, so `dout`, `nib_en` and `out_en` are checked 1 ns after the read inputs change at a falling edge, in that same cycle. `busy` is registered: it is checked at the falling edge that follows the convert edge. The bench then counts the falling edges at which `busy` is high and expects 12 or 8. `dac_code` is checked at the first and second falling edges of a run. The final result is read only after `busy` has been sampled low, so each check lands in the cycle its result is due.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_CONV = 2'd1,
      OP_READ = 2'd2
   } sarc_op_e;
endpackage

// File: rtl/sarc_decode.sv
module sarc_decode
   import sarc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en,
   input  logic chip_sel_n,
   input  logic rd_cnvt,
   output logic conv_req,
   output logic read_req
);
   sarc_op_e op;

   always_comb begin
      op = OP_NONE;
      if (chip_en && !chip_sel_n)
         op = rd_cnvt ? OP_READ : OP_CONV;
   end

   assign conv_req = (op == OP_CONV);
   assign read_req = (op == OP_READ);

   AST_IDLE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      !(chip_en && !chip_sel_n) |-> !conv_req && !read_req); // R1
endmodule

// File: rtl/sarc_seq.sv
module sarc_seq #(
   parameter int WIDTH   = 12,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_req,
   input  logic             addr_lo,
   input  logic             cmp_hi,
   output logic [WIDTH-1:0] result,
   output logic [WIDTH-1:0] trial,
   output logic             busy
);
   localparam int IDX_W = $clog2(WIDTH);
   localparam logic [IDX_W-1:0] MSB_IDX   = IDX_W'(WIDTH - 1);
   localparam logic [IDX_W-1:0] SHORT_END = IDX_W'(WIDTH - SHORT_W);

   logic [WIDTH-1:0] res_q;
   logic [IDX_W-1:0] idx_q;
   logic             short_q;
   logic             eoc_short_q;
   logic             eoc_full_q;
   logic             start;

   assign busy  = short_q ? !eoc_short_q : !eoc_full_q;
   assign start = conv_req && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q       <= '0;
         idx_q       <= MSB_IDX;
         short_q     <= 1'b0;
         eoc_short_q <= 1'b1;
         eoc_full_q  <= 1'b1;
      end else if (start) begin
         res_q       <= '0;
         idx_q       <= MSB_IDX;
         short_q     <= addr_lo;
         eoc_short_q <= 1'b0;
         eoc_full_q  <= 1'b0;
      end else if (busy) begin
         res_q[idx_q] <= cmp_hi;
         if (idx_q == SHORT_END) begin
            eoc_short_q <= 1'b1;
            if (short_q) eoc_full_q <= 1'b1;
         end
         if (idx_q == '0) eoc_full_q <= 1'b1;
         else             idx_q      <= idx_q - 1'b1;
      end
   end

   always_comb begin
      trial = res_q;
      if (busy) trial[idx_q] = 1'b1;
   end

   assign result = res_q;

   // cycle counter used only by the length checks
   logic [IDX_W:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_cnt <= '0;
      else if (start) run_cnt <= '0;
      else if (busy)  run_cnt <= run_cnt + 1'b1;
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R2
   AST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && !short_q |-> run_cnt == (IDX_W+1)'(WIDTH)); // R3
   AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && short_q |-> run_cnt == (IDX_W+1)'(SHORT_W)); // R4
   AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && short_q |-> res_q[WIDTH-SHORT_W-1:0] == '0); // R4
   AST_EOC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_full_q |-> eoc_short_q); // R3
   AST_CONV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && conv_req |=> $stable(short_q)); // R10
endmodule

// File: rtl/sarc_rdmux.sv
module sarc_rdmux #(
   parameter int WIDTH  = 12,
   parameter int BYTE_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   read_req,
   input  logic                   busy,
   input  logic                   addr_lo,
   input  logic                   wide_fmt,
   input  logic [WIDTH-1:0]       result,
   output logic [WIDTH-1:0]       dout,
   output logic [WIDTH/NIB_W-1:0] nib_en,
   output logic                   out_en
);
   localparam int LANES      = WIDTH / NIB_W;
   localparam int BYTE_LANES = BYTE_W / NIB_W;
   localparam int LOW_W      = WIDTH - BYTE_W;
   localparam int PAD_W      = BYTE_W - LOW_W;

   logic rd_ok;
   assign rd_ok = read_req && !busy;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g >= LANES - BYTE_LANES) begin : g_byte
         assign nib_en[g] = rd_ok;
      end else begin : g_wide_only
         assign nib_en[g] = rd_ok && wide_fmt;
      end
   end

   assign out_en = |nib_en;

   always_comb begin
      dout = '0;
      if (rd_ok) begin
         if (wide_fmt)
            dout = result;
         else if (!addr_lo)
            dout[WIDTH-1 -: BYTE_W] = result[WIDTH-1 -: BYTE_W];
         else
            dout[WIDTH-1 -: BYTE_W] = {result[LOW_W-1:0], {PAD_W{1'b0}}};
      end
   end

   AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !out_en && dout == '0); // R6
   AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_en && !wide_fmt |-> dout[LOW_W-1:0] == '0); // R8
   AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      out_en && !wide_fmt && addr_lo |-> dout[LOW_W +: PAD_W] == '0); // R9
endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl #(
   parameter int WIDTH   = 12,
   parameter int SHORT_W = 8,
   parameter int BYTE_W  = 8,
   parameter int NIB_W   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   chip_en,
   input  logic                   chip_sel_n,
   input  logic                   rd_cnvt,
   input  logic                   addr_lo,
   input  logic                   wide_fmt,
   input  logic                   cmp_hi,
   output logic [WIDTH-1:0]       dac_code,
   output logic                   busy,
   output logic [WIDTH-1:0]       dout,
   output logic [WIDTH/NIB_W-1:0] nib_en,
   output logic                   out_en
);
   if (WIDTH % NIB_W != 0) begin : g_bad_nib
      $error("WIDTH must be a whole number of nibble lanes");
   end
   if (BYTE_W % NIB_W != 0 || BYTE_W >= WIDTH || 2*BYTE_W <= WIDTH) begin : g_bad_byte
      $error("BYTE_W must be lane aligned and hold the low part with padding");
   end
   if (SHORT_W < 1 || SHORT_W >= WIDTH) begin : g_bad_short
      $error("SHORT_W must lie between 1 and WIDTH-1");
   end

   logic             conv_req;
   logic             read_req;
   logic [WIDTH-1:0] result;

   sarc_decode u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_en    (chip_en),
      .chip_sel_n (chip_sel_n),
      .rd_cnvt    (rd_cnvt),
      .conv_req   (conv_req),
      .read_req   (read_req)
   );

   sarc_seq #(.WIDTH(WIDTH), .SHORT_W(SHORT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_req (conv_req),
      .addr_lo  (addr_lo),
      .cmp_hi   (cmp_hi),
      .result   (result),
      .trial    (dac_code),
      .busy     (busy)
   );

   sarc_rdmux #(.WIDTH(WIDTH), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .read_req (read_req),
      .busy     (busy),
      .addr_lo  (addr_lo),
      .wide_fmt (wide_fmt),
      .result   (result),
      .dout     (dout),
      .nib_en   (nib_en),
      .out_en   (out_en)
   );
endmodule

// File: tb/sarc_ctrl_tb.sv
module sarc_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_en = 1'b0;
   logic        chip_sel_n = 1'b1;
   logic        rd_cnvt = 1'b1;
   logic        addr_lo = 1'b0;
   logic        wide_fmt = 1'b1;
   logic        cmp_hi;
   logic [11:0] dac_code;
   logic        busy;
   logic [11:0] dout;
   logic [2:0]  nib_en;
   logic        out_en;
   logic [11:0] vin = '0;
   int          n_chk = 0;
   int          n_err = 0;

   always #2.5 clk = ~clk;

   assign cmp_hi = (dac_code <= vin);

   sarc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
      .rd_cnvt(rd_cnvt), .addr_lo(addr_lo), .wide_fmt(wide_fmt), .cmp_hi(cmp_hi),
      .dac_code(dac_code), .busy(busy), .dout(dout), .nib_en(nib_en), .out_en(out_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      chip_en = 1'b0; chip_sel_n = 1'b1; rd_cnvt = 1'b1;
   endtask

   task automatic do_read(input logic fmt, input logic a, input logic [11:0] exp_d,
                          input logic [2:0] exp_n, input string req);
      @(negedge clk);
      wide_fmt = fmt; addr_lo = a; chip_en = 1'b1; chip_sel_n = 1'b0; rd_cnvt = 1'b1;
      #1;
      chk(req, 32'(dout), 32'(exp_d));
      chk(req, 32'(nib_en), 32'(exp_n));
      chk(req, 32'(out_en), 32'(exp_n != 3'b000));
      @(negedge clk);
      go_idle();
   endtask

   // start a conversion, count busy cycles, probe trial codes, blocked read, late commands
   task automatic run_conv(input logic a, input logic [11:0] v, input int exp_len,
                           input bit disturb, input string req);
      int n = 0;
      vin = v;
      @(negedge clk);
      chip_en = 1'b1; chip_sel_n = 1'b0; rd_cnvt = 1'b0; addr_lo = a;
      @(negedge clk);
      go_idle();
      chk("R2 busy after convert edge", 32'(busy), 1);
      while (busy && n < 100) begin
         n++;
         go_idle();
         if (n == 1) chk("R5 first trial", 32'(dac_code), 32'h800);
         if (n == 2) begin
            chk("R5 second trial", 32'(dac_code), 32'({v[11], 1'b1, 10'b0}));
            chip_en = 1'b1; chip_sel_n = 1'b0; rd_cnvt = 1'b1;
            #1;
            chk("R6 read blocked out_en", 32'(out_en), 0);
            chk("R6 read blocked nib_en", 32'(nib_en), 0);
            chk("R6 read blocked dout", 32'(dout), 0);
         end
         if (n >= 3 && disturb) begin
            // R10 convert while busy, R12 address flipped mid-run
            chip_en = 1'b1; chip_sel_n = 1'b0; rd_cnvt = 1'b0; addr_lo = ~a;
         end
         @(negedge clk);
      end
      go_idle();
      chk(req, 32'(n), 32'(exp_len));
   endtask

   task automatic t_reset();
      chk("R11 busy", 32'(busy), 0);
      chk("R11 out_en", 32'(out_en), 0);
      chk("R11 nib_en", 32'(nib_en), 0);
      chk("R11 dout", 32'(dout), 0);
   endtask

   task automatic t_no_select();
      @(negedge clk);
      chip_en = 1'b0; chip_sel_n = 1'b0; rd_cnvt = 1'b0;
      @(negedge clk);
      chk("R1 convert without enable", 32'(busy), 0);
      chip_en = 1'b1; chip_sel_n = 1'b1; rd_cnvt = 1'b0;
      @(negedge clk);
      chk("R1 convert without select", 32'(busy), 0);
      rd_cnvt = 1'b1;
      #1;
      chk("R1 read without select out_en", 32'(out_en), 0);
      chk("R1 read without select dout", 32'(dout), 0);
      chip_en = 1'b0; chip_sel_n = 1'b0;
      #1;
      chk("R1 read without enable nib_en", 32'(nib_en), 0);
      go_idle();
   endtask

   task automatic t_full(input logic [11:0] v);
      run_conv(1'b0, v, 12, 1'b0, "R3 full cycle length");
      do_read(1'b1, 1'b0, v, 3'b111, "R3 R7 full word read");
   endtask

   task automatic t_short(input logic [11:0] v);
      run_conv(1'b1, v, 8, 1'b0, "R4 short cycle length");
      do_read(1'b1, 1'b0, {v[11:4], 4'b0}, 3'b111, "R4 short result low zero");
   endtask

   task automatic t_bytes(input logic [11:0] v);
      run_conv(1'b0, v, 12, 1'b0, "R3 full cycle length");
      do_read(1'b0, 1'b0, {v[11:4], 4'b0}, 3'b110, "R8 high byte read");
      do_read(1'b0, 1'b1, {v[3:0], 8'b0}, 3'b110, "R9 low byte read");
   endtask

   task automatic t_disturb();
      run_conv(1'b0, 12'h3C7, 12, 1'b1, "R10 R12 full length kept");
      do_read(1'b1, 1'b0, 12'h3C7, 3'b111, "R10 result kept");
      run_conv(1'b1, 12'hB6D, 8, 1'b1, "R10 R12 short length kept");
      do_read(1'b1, 1'b0, 12'hB60, 3'b111, "R10 short result kept");
   endtask

   initial begin
      #200_000;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_select();
      t_full(12'hA5C);
      t_full(12'h000);
      t_full(12'hFFF);
      t_full(12'h801);
      t_short(12'h5A9);
      t_short(12'hFFF);
      t_bytes(12'hD37);
      t_bytes(12'h0F1);
      t_disturb();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule